// File: doc/BRIEF.md
# Synchronizable Square-Wave Divider

This block turns a timing reference into a selectable square wave for an output pin. A 4-bit rate code picks one of sixteen power-of-two rates, from 32.768 kHz down to 0.5 Hz. The block is clocked at twice its fastest output rate, so the nominal clock is 65.536 kHz. The divider chain behind it is a binary counter. The output is taken from one of its stages through a register, and that register only loads when the newly chosen stage changes, so the pin never shows a partial pulse.

Software can align the wave with an external tick by raising a sync input. While sync is high, every stage slower than 4096 Hz is cleared and held. The four fastest stages (32.768, 16.384, 8.192 and 4.096 kHz) keep counting. Dropping sync lets the held stages start again from zero. The result lines up with the moment of release to within one 4096 Hz period.

An enable input forces the output level to 0 when it is low. A power-fail input removes the pin drive, whatever the enable says.

Top module: `sqw_divider`

## Requirements
- R1: While reset is asserted, `sqw_out` is 0 and `sqw_oe` is 1 (with `pwr_fail` low).
- R2: For rate codes 0 to 12, with enable high and sync low, `sqw_out` is high for exactly 2^n clock cycles and then low for exactly 2^n clock cycles, where n is the code.
- R3: For rate codes 13, 14 and 15, the wave runs at 2 Hz, 1 Hz and 0.5 Hz. Each half period is 2^(n+1) clock cycles, so stage n+1 of the chain is used.
- R4: While `enable` is 0, `sqw_out` is 0.
- R5: While `pwr_fail` is 1, `sqw_oe` is 0 and `sqw_out` is 0, whatever the value of `enable`.
- R6: For codes 4 and above, `sqw_out` is 0 from the first clock edge that sees `sync` high, and it stays 0 while `sync` stays high.
- R7: Codes 0 to 3 keep their exact period while `sync` is high.
- R8: On release of `sync` under code n of 4 or above, the first rising edge of `sqw_out` comes between 2^k-15 and 2^k clock edges after release, where k is the chain stage used (k = n for codes up to 12, k = n+1 above).
- R9: After the rate code changes, `sqw_out` keeps its level until the newly selected stage next toggles. It then follows that stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider clock, twice the fastest output rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel | input | 4 | Output rate code |
| enable | input | 1 | 1 lets the wave reach the pin, 0 forces the level to 0 |
| sync | input | 1 | 1 clears and holds the stages slower than 4096 Hz |
| pwr_fail | input | 1 | 1 removes the pin drive |
| sqw_out | output | 1 | Square-wave level |
| sqw_oe | output | 1 | Output enable for the pin's tri-state driver |

## Verification
The hardest case to reach from the ports is a slow rate, where a single period is longer than the whole run can afford. The bench handles this with sync. It holds the slow stages in reset, releases them, and measures only the time to the first rising edge. The fast lower stages run at an unknown phase at that moment, so this time is checked against a window 16 cycles wide. The glitch-free rate change is caught right after a rising edge of stage 10, when every lower stage is known to be zero. Switching to code 8 at that point must hold the output high for 512 cycles. A plain multiplexer would drop it at once.

// File: rtl/sqw_pkg.sv
`timescale 1ns/1ps
package sqw_pkg;

  // Maps a rate code onto the divider stage it taps. From skip_from upward
  // the codes step over one stage.
  function automatic int stage_of(input int code, input int skip_from);
    return (code >= skip_from) ? code + 1 : code;
  endfunction

endpackage

// File: rtl/sqw_reset_sync.sv
`timescale 1ns/1ps
module sqw_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_s_n = stg_q[1];

endmodule

// File: rtl/sqw_prescaler.sv
`timescale 1ns/1ps
module sqw_prescaler #(
  parameter int STAGES      = 17,
  parameter int FAST_STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  output logic [STAGES-1:0] stage_q,
  output logic [STAGES-1:0] stage_tgl,
  output logic [STAGES-1:0] stage_clr
);

  localparam int SLOW_STAGES = STAGES - FAST_STAGES;

  logic [FAST_STAGES-1:0] lo_q, lo_d;
  logic [SLOW_STAGES-1:0] hi_q, hi_d;
  logic                   lo_wrap;

  // next state
  always_comb begin
    lo_wrap = &lo_q;
    lo_d    = lo_q + 1'b1;
    if (sync)         hi_d = '0;
    else if (lo_wrap) hi_d = hi_q + 1'b1;
    else              hi_d = hi_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign stage_q = {hi_q, lo_q};

  // Per-stage toggle and clear flags. The fast stages ignore sync.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic carry_in;
    if (k == 0) begin : g_first
      assign carry_in = 1'b1;
    end else begin : g_rest
      assign carry_in = &stage_q[k-1:0];
    end
    if (k < FAST_STAGES) begin : g_fast
      assign stage_tgl[k] = carry_in;
      assign stage_clr[k] = 1'b0;
    end else begin : g_held
      assign stage_tgl[k] = carry_in & ~sync;
      assign stage_clr[k] = sync;
    end
  end

  // R6
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (hi_q == '0));

  // R2
  slow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && (lo_q != '1)) |=> $stable(hi_q));

  // R7
  fast_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (lo_q != $past(lo_q)));

endmodule

// File: rtl/sqw_tap_select.sv
`timescale 1ns/1ps
module sqw_tap_select #(
  parameter int SEL_W     = 4,
  parameter int STAGES    = 17,
  parameter int SKIP_FROM = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rate_sel,
  input  logic [STAGES-1:0] stage_q,
  input  logic [STAGES-1:0] stage_tgl,
  input  logic [STAGES-1:0] stage_clr,
  output logic              sq_q
);

  localparam int STG_W = $clog2(STAGES);

  logic [STG_W-1:0] tap;
  logic             tap_tgl, tap_clr, load, sq_d;

  // next state
  always_comb begin
    tap     = STG_W'(sqw_pkg::stage_of(int'(rate_sel), SKIP_FROM));
    tap_tgl = stage_tgl[tap];
    tap_clr = stage_clr[tap];
    load    = tap_tgl | tap_clr;
    sq_d    = tap_clr ? 1'b0 : ~stage_q[tap];
  end

  // registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sq_q <= 1'b0;
    else if (load) sq_q <= sq_d;
  end

  // R9
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tap_tgl || tap_clr) |=> $stable(sq_q));

  // R6
  sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_clr |=> !sq_q);

endmodule

// File: rtl/sqw_divider.sv
`timescale 1ns/1ps
module sqw_divider #(
  parameter int SEL_W       = 4,
  parameter int FAST_STAGES = 4,
  parameter int SKIP_FROM   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             enable,
  input  logic             sync,
  input  logic             pwr_fail,
  output logic             sqw_out,
  output logic             sqw_oe
);

  localparam int N_CODES = 1 << SEL_W;
  localparam int STAGES  = N_CODES + 1;

  logic              rst_s_n;
  logic [STAGES-1:0] stage_q, stage_tgl, stage_clr;
  logic              sq_q;

  sqw_reset_sync i_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sqw_prescaler #(
    .STAGES      (STAGES),
    .FAST_STAGES (FAST_STAGES)
  ) i_pre (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sync      (sync),
    .stage_q   (stage_q),
    .stage_tgl (stage_tgl),
    .stage_clr (stage_clr)
  );

  sqw_tap_select #(
    .SEL_W     (SEL_W),
    .STAGES    (STAGES),
    .SKIP_FROM (SKIP_FROM)
  ) i_tap (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .rate_sel  (rate_sel),
    .stage_q   (stage_q),
    .stage_tgl (stage_tgl),
    .stage_clr (stage_clr),
    .sq_q      (sq_q)
  );

  assign sqw_oe  = ~pwr_fail;
  assign sqw_out = sq_q & enable & ~pwr_fail;

  // R4
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !enable |-> !sqw_out);

  // R5
  float_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    pwr_fail |-> (!sqw_oe && !sqw_out));

endmodule

// File: tb/test_sqw_divider.sv
`timescale 1ns/1ps
module test_sqw_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       enable = 1'b1;
  logic       sync = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       sqw_out, sqw_oe;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sqw_divider i_sqw_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .enable   (enable),
    .sync     (sync),
    .pwr_fail (pwr_fail),
    .sqw_out  (sqw_out),
    .sqw_oe   (sqw_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stage_of(input int code);
    return (code >= 13) ? code + 1 : code;
  endfunction

  task automatic wait_lvl(input logic v, input int lim, output int n);
    n = 0;
    while (sqw_out !== v && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic half_periods(input int k, output int nh, output int nl);
    int n;
    int lim;
    lim = (4 << k) + 8;
    wait_lvl(1'b0, lim, n);
    wait_lvl(1'b1, lim, n);
    wait_lvl(1'b0, lim, nh);
    wait_lvl(1'b1, lim, nl);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, nh, nl, bad, k;
    // R1 reset state
    repeat (4) @(negedge clk);
    check(sqw_out === 1'b0, "R1 level in reset", int'(sqw_out), 0);
    check(sqw_oe === 1'b1, "R1 drive in reset", int'(sqw_oe), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 periods for codes 0..10
    for (int c = 0; c <= 10; c++) begin
      rate_sel = 4'(c);
      k = stage_of(c);
      half_periods(k, nh, nl);
      check(nh == (1 << k), $sformatf("R2 high time code %0d", c), nh, 1 << k);
      check(nl == (1 << k), $sformatf("R2 low time code %0d", c), nl, 1 << k);
    end

    // R4 enable low
    rate_sel = 4'd0;
    enable = 1'b0;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (sqw_out !== 1'b0) bad++;
    end
    check(bad == 0, "R4 level forced low", bad, 0);
    enable = 1'b1;

    // R5 power-fail, with enable high and then low
    pwr_fail = 1'b1;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (sqw_out !== 1'b0 || sqw_oe !== 1'b0) bad++;
      if (i == 8) enable = 1'b0;
    end
    check(bad == 0, "R5 pin released in power-fail", bad, 0);
    pwr_fail = 1'b0;
    enable = 1'b1;

    // R7 fast codes unaffected by sync
    sync = 1'b1;
    for (int c = 2; c <= 3; c++) begin
      rate_sel = 4'(c);
      half_periods(c, nh, nl);
      check(nh == (1 << c), $sformatf("R7 high time code %0d under sync", c), nh, 1 << c);
      check(nl == (1 << c), $sformatf("R7 low time code %0d under sync", c), nl, 1 << c);
    end
    sync = 1'b0;

    // R6 slow code cleared and held
    rate_sel = 4'd6;
    wait_lvl(1'b0, 300, n);
    wait_lvl(1'b1, 300, n);
    sync = 1'b1;
    @(negedge clk);
    check(sqw_out === 1'b0, "R6 low after sync edge", int'(sqw_out), 0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sqw_out !== 1'b0) bad++;
    end
    check(bad == 0, "R6 held low under sync", bad, 0);

    // R8 and R3 first rise after sync release
    for (int c = 11; c <= 15; c++) begin
      rate_sel = 4'(c);
      k = stage_of(c);
      sync = 1'b1;
      repeat (2) @(negedge clk);
      sync = 1'b0;
      wait_lvl(1'b1, (1 << k) + 32, n);
      if (c >= 13)
        check(n >= (1 << k) - 15 && n <= (1 << k),
              $sformatf("R3 first rise code %0d", c), n, 1 << k);
      else
        check(n >= (1 << k) - 15 && n <= (1 << k),
              $sformatf("R8 first rise code %0d", c), n, 1 << k);
    end

    // R9 rate change holds level until new stage toggles
    rate_sel = 4'd10;
    wait_lvl(1'b0, 4200, n);
    wait_lvl(1'b1, 4200, n);
    rate_sel = 4'd8;
    wait_lvl(1'b0, 2000, n);
    check(n == 512, "R9 level held after rate change", n, 512);
    wait_lvl(1'b1, 2000, n);
    check(n == 256, "R9 new stage followed", n, 256);

    finish_run();
  end

endmodule